// File: doc/BRIEF.md
# ISA Bus Cycle Master

This block turns a single host request into one or two ISA-style bus cycles. The host presents an address, write data, a direction bit, a memory/I-O select bit and a requested width, then pulses `req` while the block is idle. The block raises BALE for one SCLK with the address and SBHE# already valid. It then drives the command strobe that matches the request for a number of SCLK periods that it settles at run time.

The cycle length depends on what the slave answers. On the BALE cycle the block samples the 16-bit chip-select that belongs to the cycle type: MEMCS16# for memory, IOCS16# for I/O. A wide request that the slave acknowledges becomes one 3-SCLK, 16-bit cycle. A wide request that the slave does not acknowledge becomes two 8-bit cycles at consecutive byte addresses. A plain 8-bit cycle lasts 6 SCLKs. ZEROWS# can cut an 8-bit cycle to 3 SCLKs. IOCHRDY held low stretches any cycle by whole wait states, up to a programmable limit; reaching that limit ends the transfer and flags an error. Every time is counted in SCLK periods, and `clk` is SCLK.

When the transfer completes, the block returns a one-cycle `done` together with the assembled read data and the error flag.

Top module: `isa_cycle_master`

## Requirements
- R1: After reset `bale` is low, `busy`, `done`, `err` and `sd_oe` are low, and all six command strobes (active-low) are high.
- R2: Each bus cycle starts with `bale` high for exactly one SCLK. The address is on `bus_addr` in that cycle. The command strobe goes active in the next SCLK and is never active while `bale` is high.
- R3: A standard 8-bit cycle lasts 6 SCLKs from the BALE cycle to the last command cycle, which means 5 SCLKs of active command when `iochrdy` is high. Only SD[7:0] is used and `sbhe_n` is high during the command.
- R4: A wide request (`req_wide`=1) whose slave drives the matching chip-select low on the BALE cycle runs one 16-bit cycle. The matching chip-select is `memcs16_n` for memory and `iocs16_n` for I/O; the other one is ignored. That cycle has 2 command SCLKs (3 in total), keeps `sbhe_n` low during the command, and moves all 16 bits.
- R5: In an 8-bit cycle, `zerows_n` sampled low at the end of the second command SCLK ends the command there, giving a 3-SCLK cycle. This holds even if `iochrdy` is low.
- R6: When `iochrdy` is low at the edge where the command would end, the command stays active one more SCLK per such edge. It ends on the first edge at which `iochrdy` is high.
- R7: After TIMEOUT wait states with `iochrdy` still low, the command ends and `err` is reported with `done`. A wide request that times out on its first byte runs no second cycle.
- R8: A wide request whose slave does not assert the chip-select runs two 8-bit cycles at `A` and `A+1`. The first cycle carries the low byte and the second the high byte, both on SD[7:0]. The read result is {second byte, first byte}.
- R9: Memory cycles use `memr_n`/`memw_n` and I/O cycles use `ior_n`/`iow_n`, with at most one of these four low at a time. `smemr_n`/`smemw_n` follow the memory strobes only when address bits [23:20] are all zero.
- R10: On writes, `sd_oe` is high from the first command SCLK through one SCLK after the command ends. On reads it stays low. Read data is latched on the edge that ends the command, and a narrow read returns zero in bits [15:8].
- R11: `done` is a one-SCLK pulse in which `rd_data` and `err` are valid. `busy` is high from acceptance through the `done` cycle and low in the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SCLK, rising-edge |
| rst | input | 1 | synchronous active-high reset |
| req | input | 1 | start a transfer (taken when idle) |
| req_addr | input | ADDR_W | byte address |
| req_wdata | input | 16 | write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_wide | input | 1 | 1 = 16-bit request |
| busy | output | 1 | transfer in progress |
| done | output | 1 | one-cycle completion pulse |
| rd_data | output | 16 | read result |
| err | output | 1 | wait-state timeout |
| bale | output | 1 | address latch enable |
| bus_addr | output | ADDR_W | bus address |
| sbhe_n | output | 1 | high byte enable, active low |
| memr_n | output | 1 | memory read strobe |
| memw_n | output | 1 | memory write strobe |
| smemr_n | output | 1 | low-1MB memory read strobe |
| smemw_n | output | 1 | low-1MB memory write strobe |
| ior_n | output | 1 | I/O read strobe |
| iow_n | output | 1 | I/O write strobe |
| sd_oe | output | 1 | write data drive enable |
| sd_out | output | 16 | write data to bus |
| sd_in | input | 16 | read data from bus |
| memcs16_n | input | 1 | memory 16-bit acknowledge |
| iocs16_n | input | 1 | I/O 16-bit acknowledge |
| zerows_n | input | 1 | zero-wait-state request |
| iochrdy | input | 1 | channel ready, low inserts waits |

## Verification
The bench builds the block with TIMEOUT=8 and keeps the default 6/3/3 cycle lengths. The short limit lets the bench hit a timeout in 13 command SCLKs. It also lets it place a late IOCHRDY exactly on the last legal edge, which probes the limit from both sides within a few hundred cycles. The slave model deliberately drives the chip-select of the other space opposite to the one it means, so sampling the wrong chip-select shows up as a width miscompare.

// File: rtl/isa_pkg.sv
package isa_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_RECOV,
        PH_DONE
    } phase_t;

    typedef struct packed {
        logic write;
        logic io;
        logic wide;
    } kind_t;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
    } strobe_t;

    function automatic strobe_t pick_strobe(input kind_t k, input logic active);
        strobe_t s;
        s.mem_rd = active && !k.io && !k.write;
        s.mem_wr = active && !k.io &&  k.write;
        s.io_rd  = active &&  k.io && !k.write;
        s.io_wr  = active &&  k.io &&  k.write;
        return s;
    endfunction

endpackage

// File: rtl/isa_width_sel.sv
module isa_width_sel (
    input  logic is_io,
    input  logic want_wide,
    input  logic second,
    input  logic memcs16_n,
    input  logic iocs16_n,
    output logic wide16
);
    logic ack16;

    always_comb begin
        ack16  = is_io ? !iocs16_n : !memcs16_n;
        wide16 = want_wide && !second && ack16;
    end
endmodule

// File: rtl/isa_wait_ctr.sv
module isa_wait_ctr #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    assign hit = (cnt == CW'(LIMIT));
endmodule

// File: rtl/isa_cycle_master.sv
module isa_cycle_master
    import isa_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int LEN8    = 6,
    parameter int LEN16   = 3,
    parameter int LEN_ZWS = 3,
    parameter int TIMEOUT = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic              req_write,
    input  logic              req_io,
    input  logic              req_wide,
    output logic              busy,
    output logic              done,
    output logic [15:0]       rd_data,
    output logic              err,
    output logic              bale,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              sbhe_n,
    output logic              memr_n,
    output logic              memw_n,
    output logic              smemr_n,
    output logic              smemw_n,
    output logic              ior_n,
    output logic              iow_n,
    output logic              sd_oe,
    output logic [15:0]       sd_out,
    input  logic [15:0]       sd_in,
    input  logic              memcs16_n,
    input  logic              iocs16_n,
    input  logic              zerows_n,
    input  logic              iochrdy
);
    localparam int KW = $clog2(LEN8 + 1);
    localparam logic [KW-1:0] SPAN8  = KW'(LEN8 - 1);
    localparam logic [KW-1:0] SPAN16 = KW'(LEN16 - 1);
    localparam logic [KW-1:0] SPANZ  = KW'(LEN_ZWS - 1);
    localparam int LOW_MB_BIT = 20;

    phase_t            ph;
    kind_t             kind;
    logic [ADDR_W-1:0] addr_q;
    logic [15:0]       wd_q;
    logic [15:0]       rd_q;
    logic              err_q;
    logic              second;
    logic              wide16_q;
    logic [KW-1:0]     k;

    logic    wide_now;
    logic    tmo_hit;
    logic    at_std, zw_end, rdy_end, tmo_end, end_cmd, wait_inc;
    logic    cmd_on, low_mb;
    strobe_t stb;

    isa_width_sel u_wsel (
        .is_io     (kind.io),
        .want_wide (kind.wide),
        .second    (second),
        .memcs16_n (memcs16_n),
        .iocs16_n  (iocs16_n),
        .wide16    (wide_now)
    );

    isa_wait_ctr #(.LIMIT(TIMEOUT)) u_wait (
        .clk (clk),
        .rst (rst),
        .clr (ph != PH_CMD),
        .inc (wait_inc),
        .hit (tmo_hit)
    );

    always_comb begin
        cmd_on   = (ph == PH_CMD);
        at_std   = cmd_on && (k >= (wide16_q ? SPAN16 : SPAN8));
        zw_end   = cmd_on && !wide16_q && !zerows_n && (k >= SPANZ);
        rdy_end  = at_std && iochrdy;
        tmo_end  = at_std && !iochrdy && tmo_hit;
        end_cmd  = zw_end || rdy_end || tmo_end;
        wait_inc = at_std && !iochrdy && !tmo_hit && !zw_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            kind     <= '0;
            addr_q   <= '0;
            wd_q     <= '0;
            rd_q     <= '0;
            err_q    <= 1'b0;
            second   <= 1'b0;
            wide16_q <= 1'b0;
            k        <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (req) begin
                    addr_q <= req_addr;
                    wd_q   <= req_wdata;
                    kind   <= '{write: req_write, io: req_io, wide: req_wide};
                    second <= 1'b0;
                    rd_q   <= '0;
                    err_q  <= 1'b0;
                    ph     <= PH_ADDR;
                end
                PH_ADDR: begin
                    wide16_q <= wide_now;
                    k        <= KW'(1);
                    ph       <= PH_CMD;
                end
                PH_CMD: begin
                    if (end_cmd) begin
                        if (wide16_q)
                            rd_q <= sd_in;
                        else if (second)
                            rd_q[15:8] <= sd_in[7:0];
                        else
                            rd_q[7:0] <= sd_in[7:0];
                        err_q <= tmo_end && !zw_end;
                        ph    <= PH_RECOV;
                    end else if (k != SPAN8) begin
                        k <= k + 1'b1;
                    end
                end
                PH_RECOV: begin
                    if (kind.wide && !wide16_q && !second && !err_q) begin
                        second <= 1'b1;
                        addr_q <= addr_q + 1'b1;
                        ph     <= PH_ADDR;
                    end else begin
                        ph <= PH_DONE;
                    end
                end
                PH_DONE: ph <= PH_IDLE;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        stb      = pick_strobe(kind, cmd_on);
        low_mb   = (addr_q[ADDR_W-1:LOW_MB_BIT] == '0);
        bale     = (ph == PH_ADDR);
        busy     = (ph != PH_IDLE);
        done     = (ph == PH_DONE);
        rd_data  = rd_q;
        err      = err_q && done;
        bus_addr = addr_q;
        memr_n   = !stb.mem_rd;
        memw_n   = !stb.mem_wr;
        smemr_n  = !(stb.mem_rd && low_mb);
        smemw_n  = !(stb.mem_wr && low_mb);
        ior_n    = !stb.io_rd;
        iow_n    = !stb.io_wr;
        sbhe_n   = bale ? !(kind.wide && !second) : !(cmd_on && wide16_q);
        sd_oe    = kind.write && (cmd_on || ph == PH_RECOV);
        sd_out   = wide16_q ? wd_q : {8'h00, (second ? wd_q[15:8] : wd_q[7:0])};
    end
endmodule

// File: rtl/isa_cycle_master_chk.sv
module isa_cycle_master_chk (
    input logic clk,
    input logic rst,
    input logic bale,
    input logic memr_n,
    input logic memw_n,
    input logic smemr_n,
    input logic smemw_n,
    input logic ior_n,
    input logic iow_n,
    input logic sd_oe,
    input logic done,
    input logic busy
);
    // R2
    bale_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        bale |=> !bale);

    // R2
    bale_no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        bale |-> (memr_n && memw_n && ior_n && iow_n));

    // R9
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!memr_n, !memw_n, !ior_n, !iow_n}));

    // R9
    smem_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (!smemr_n |-> !memr_n) and (!smemw_n |-> !memw_n));

    // R10
    no_drive_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!memr_n || !ior_n) |-> !sd_oe);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));
endmodule

bind isa_cycle_master isa_cycle_master_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .bale    (bale),
    .memr_n  (memr_n),
    .memw_n  (memw_n),
    .smemr_n (smemr_n),
    .smemw_n (smemw_n),
    .ior_n   (ior_n),
    .iow_n   (iow_n),
    .sd_oe   (sd_oe),
    .done    (done),
    .busy    (busy)
);

// File: tb/sim_isa_cycle_master.sv
module sim_isa_cycle_master;
    localparam int AW  = 24;
    localparam int TMO = 8;

    typedef struct {
        logic [15:0] rdata;
        logic        chk_rd;
        logic [15:0] wcap;
        logic        chk_wr;
        logic        err;
        int          cmdcyc;
        int          nbale;
        logic        w16;
        logic [3:0]  mask;
        int          smem;
        int          oecyc;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic          req_write = 1'b0, req_io = 1'b0, req_wide = 1'b0;
    logic          busy, done, err, bale, sbhe_n, sd_oe;
    logic          memr_n, memw_n, smemr_n, smemw_n, ior_n, iow_n;
    logic [15:0]   rd_data, sd_out, sd_in;
    logic [AW-1:0] bus_addr;
    logic          memcs16_n, iocs16_n, zerows_n, iochrdy;

    logic cfg_io = 1'b0, cfg_cs16 = 1'b0, cfg_zw = 1'b0;
    int   cfg_hold = 0;
    int   run = 0;

    int   n_chk = 0, n_fail = 0;
    exp_t q[$];

    int          m_cmd = 0, m_bale = 0, m_smem = 0, m_oe = 0;
    logic        m_w16 = 1'b0;
    logic [3:0]  m_mask = '0;
    logic [15:0] m_wcap = '0;

    always #4 clk = ~clk;

    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    // slave model: the chip-select of the other space is driven opposite
    assign memcs16_n = cfg_io ? cfg_cs16 : !cfg_cs16;
    assign iocs16_n  = cfg_io ? !cfg_cs16 : cfg_cs16;
    assign zerows_n  = !cfg_zw;
    assign iochrdy   = (run > cfg_hold);
    assign sd_in     = {pat(bus_addr + 1'b1), pat(bus_addr)};

    isa_cycle_master #(.ADDR_W(AW), .TIMEOUT(TMO)) u0 (
        .clk(clk), .rst(rst), .req(req), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io),
        .req_wide(req_wide), .busy(busy), .done(done), .rd_data(rd_data),
        .err(err), .bale(bale), .bus_addr(bus_addr), .sbhe_n(sbhe_n),
        .memr_n(memr_n), .memw_n(memw_n), .smemr_n(smemr_n),
        .smemw_n(smemw_n), .ior_n(ior_n), .iow_n(iow_n), .sd_oe(sd_oe),
        .sd_out(sd_out), .sd_in(sd_in), .memcs16_n(memcs16_n),
        .iocs16_n(iocs16_n), .zerows_n(zerows_n), .iochrdy(iochrdy)
    );

    wire cmd_any = !memr_n || !memw_n || !ior_n || !iow_n;
    wire wr_any  = !memw_n || !iow_n;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        run <= cmd_any ? run + 1 : 0;
        if (!rst) begin
            if (bale) m_bale++;
            if (cmd_any) begin
                m_cmd++;
                m_mask |= {!memr_n, !memw_n, !ior_n, !iow_n};
                if (!sbhe_n) m_w16 = 1'b1;
                if (!smemr_n || !smemw_n) m_smem++;
                if (wr_any) begin
                    if (!sbhe_n)        m_wcap = sd_out;
                    else if (m_bale == 1) m_wcap[7:0]  = sd_out[7:0];
                    else                  m_wcap[15:8] = sd_out[7:0];
                end
            end
            if (sd_oe) m_oe++;
            if (done) begin
                if (q.size() == 0) begin
                    check(1'b0, "done without request", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(m_cmd == e.cmdcyc, {e.tag, " command cycles"}, m_cmd, e.cmdcyc);
                    check(m_bale == e.nbale, {e.tag, " bale count"}, m_bale, e.nbale);
                    check(m_w16 == e.w16,    {e.tag, " 16-bit cycle"}, m_w16, e.w16);
                    check(m_mask == e.mask,  {e.tag, " strobe set"}, m_mask, e.mask);
                    check(m_smem == e.smem,  {e.tag, " low-1MB strobe cycles"}, m_smem, e.smem);
                    check(m_oe == e.oecyc,   {e.tag, " sd_oe cycles"}, m_oe, e.oecyc);
                    check(err == e.err,      {e.tag, " err"}, err, e.err);
                    if (e.chk_rd) check(rd_data == e.rdata, {e.tag, " read data"}, rd_data, e.rdata);
                    if (e.chk_wr) check(m_wcap == e.wcap, {e.tag, " write data"}, m_wcap, e.wcap);
                end
                m_cmd = 0; m_bale = 0; m_smem = 0; m_oe = 0;
                m_w16 = 1'b0; m_mask = '0; m_wcap = '0;
            end
        end
    end

    task automatic txn(input string tag, input logic [AW-1:0] a, input logic [15:0] wd,
                       input logic wr, input logic io, input logic wide,
                       input logic cs16, input logic zw, input int hold);
        exp_t e;
        int   span, c, nb;
        logic w16, terr;
        w16  = wide && cs16;
        span = w16 ? 2 : 5;
        terr = 1'b0;
        if (!w16 && zw)                  c = 2;
        else if (hold + 1 <= span + TMO) c = (hold + 1 > span) ? hold + 1 : span;
        else begin c = span + TMO; terr = 1'b1; end
        nb = (wide && !cs16 && !terr) ? 2 : 1;
        e.tag    = tag;
        e.err    = terr;
        e.cmdcyc = c * nb;
        e.nbale  = nb;
        e.w16    = w16;
        e.mask   = {!io && !wr, !io && wr, io && !wr, io && wr};
        e.smem   = (!io && a[23:20] == 4'h0) ? c * nb : 0;
        e.oecyc  = wr ? (c + 1) * nb : 0;
        e.chk_rd = !wr && !terr;
        e.rdata  = wide ? {pat(a + 1'b1), pat(a)} : {8'h00, pat(a)};
        e.chk_wr = wr && !terr;
        e.wcap   = wide ? wd : {8'h00, wd[7:0]};
        q.push_back(e);
        cfg_io = io; cfg_cs16 = cs16; cfg_zw = zw; cfg_hold = hold;
        @(negedge clk);
        req_addr = a; req_wdata = wd; req_write = wr; req_io = io; req_wide = wide;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        do @(negedge clk); while (!done);
        @(negedge clk);
        check(!busy && !done, {tag, " R11 busy clear after done"}, busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(!bale && !busy && !done && !err && !sd_oe, "R1 control outputs idle",
              {bale, busy, done, err, sd_oe}, 0);
        check(memr_n && memw_n && smemr_n && smemw_n && ior_n && iow_n,
              "R1 strobes high", {memr_n, memw_n, smemr_n, smemw_n, ior_n, iow_n}, 6'h3f);

        txn("R3 R9 R10 mem read 8-bit low MB", 24'h012345, 16'h0000, 0, 0, 0, 0, 0, 0);
        txn("R3 R9 R10 mem write 8-bit high", 24'h300010, 16'hBEEF, 1, 0, 0, 0, 0, 0);
        txn("R4 io read 16-bit",              24'h000300, 16'h0000, 0, 1, 1, 1, 0, 0);
        txn("R4 R9 mem write 16-bit low MB",  24'h000200, 16'hC0DE, 1, 0, 1, 1, 0, 0);
        txn("R8 mem read split",              24'h0A0040, 16'h0000, 0, 0, 1, 0, 0, 0);
        txn("R8 R10 io write split",          24'h0003F0, 16'h1234, 1, 1, 1, 0, 0, 0);
        txn("R5 zero-wait mem read",          24'h000777, 16'h0000, 0, 0, 0, 0, 1, 0);
        txn("R5 zero-wait beats IOCHRDY",     24'h000778, 16'h0000, 0, 1, 0, 0, 1, 5);
        txn("R6 io read 3 wait states",       24'h000310, 16'h0000, 0, 1, 0, 0, 0, 7);
        txn("R6 ready before standard end",   24'h000311, 16'h0000, 0, 1, 0, 0, 0, 3);
        txn("R6 16-bit stretched",            24'h400000, 16'h5555, 1, 0, 1, 1, 0, 4);
        txn("R7 timeout 8-bit",               24'h000320, 16'h0000, 0, 1, 0, 0, 0, 50);
        txn("R7 ready on last legal edge",    24'h000321, 16'h0000, 0, 1, 0, 0, 0, 12);
        txn("R7 R8 timeout stops split",      24'h000500, 16'hAAAA, 1, 0, 1, 0, 0, 50);
        txn("R2 R3 back-to-back read",        24'h0FFFFF, 16'h0000, 0, 0, 0, 0, 0, 0);

        check(q.size() == 0, "R11 every request completed", q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run hung actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule